// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Capture

This block sits just after a page-table walker. Each cycle it may be handed one translation request. A request carries the final page entry, any fault the walker met on the way, and the attributes of the access: whether it writes, whether it is an instruction fetch, and whether it comes from user or supervisor mode. Within that same cycle the block decides whether the access may go ahead. It also gives the read, write and execute rights that may be cached for the page, and raises an instruction or data trap when the access must be refused.

The block keeps two software-visible registers. The fault status word records how the most recent fault happened. Its layout is: bit 0 overflow, bit 1 address-valid, bits 4:2 fault type, bits 7:5 access index, bits 9:8 walk level. The fault address word holds the virtual address of that fault. Reading the status word through the read strobe clears it.

A no-fault mode and a trap-enable input decide what happens when a fault occurs. The access can be turned into a fully permitted one instead of trapping. For user accesses in no-fault mode, a protection problem is ignored outright.

Top module: `pgchk_top`

## Requirements
- R1: The access index is {write, fetch, supervisor}, where supervisor = !reqUser. The entry's access field sits at leafEntry[4:2]. A user access to field 6 or 7 yields error code 3 (privilege). Otherwise, code 2 (protection) results when a needed right is missing from the granted rights. A plain read needs R, a write needs W, and a fetch needs X. Code 0 means allowed.
- R2: The rights granted by a field, given as {R,W,X}, are: 0→100, 1→110, 2→101, 3→111, 4→001. Field 5 gives 110 to supervisor and 100 to user. Field 6 gives 101 to supervisor and 000 to user. Field 7 gives 111 to supervisor and 000 to user. A permitted access without override drives these on permR/permW/permX.
- R3: When the modified bit leafEntry[6] is 0, permW is 0 on a non-overridden grant, even if the access itself is allowed.
- R4: With noFault=1, a user access that has a permission error and no walker fault is permitted with the entry's rights. No fault is recorded.
- R5: A recorded fault sets the status word at the next clock edge. The word is: walk level in bits 9:8, access index in 7:5, fault type in 4:2, and bit 1 set.
- R6: A fault that arrives while the status word is nonzero and not being read makes the new word equal to 1 OR the fields of R5. This marks overflow.
- R7: A recorded fault loads reqAddr into faultAddr at the next clock edge.
- R8: When a fault happens and either noFault=1 or trapsEnabled=0, the access is permitted with rights 111 and no trap is raised. Otherwise permitted=0 and the rights are 000. trapInstr is raised for a fetch, and trapData for any other access.
- R9: statusRead=1 shows the current status word and clears it to 0 at the next edge. If a fault arrives in the same cycle, the new word holds the fault fields without the overflow bit.
- R10: A nonzero walkFaultType is a fault whose type field is walkFaultType. It takes priority over the permission check, and no-fault mode does not suppress it.
- R11: After reset both registers are 0. When reqValid=0, all decision outputs are 0 and, unless a read clears the status word, both registers keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqAddr | input | ADDR_W | Virtual address of the access |
| reqWrite | input | 1 | Access writes |
| reqFetch | input | 1 | Access is an instruction fetch |
| reqUser | input | 1 | Access comes from user mode |
| leafEntry | input | ENTRY_W | Final page entry from the walker |
| walkFaultType | input | 3 | Walker fault type, 0 when the walk succeeded |
| walkLevel | input | 2 | Level at which the walk ended |
| noFault | input | 1 | No-fault mode |
| trapsEnabled | input | 1 | Traps are enabled |
| statusRead | input | 1 | Read strobe for the status word, clears it |
| permitted | output | 1 | Access may proceed |
| permR | output | 1 | Read right for caching |
| permW | output | 1 | Write right for caching |
| permX | output | 1 | Execute right for caching |
| trapInstr | output | 1 | Instruction fault trap request |
| trapData | output | 1 | Data fault trap request |
| faultStatus | output | STATUS_W | Fault status word |
| faultAddr | output | ADDR_W | Fault address word |

## Verification
The assertions check several register rules on every cycle. A recorded fault must set the address-valid bit and capture the address. An unread earlier fault must raise overflow. A read with no new fault must clear the word, and idle cycles must leave both registers still. They also check that traps appear only when trapping is allowed, that at most one trap kind is raised, and that write rights never appear for an unmodified page. Only the bench's scenarios can show the exact contents of the error-code and rights tables, the precise status encodings, and the ordering when a read and a fault meet in the same cycle.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

  // Field positions inside the leaf entry
  localparam int ENT_ACC_LSB = 2;
  localparam int ENT_MOD_BIT = 6;

  // Field positions inside the fault status word
  localparam int ST_OVF_BIT = 0;
  localparam int ST_VAL_BIT = 1;
  localparam int ST_TYPE_LSB = 2;
  localparam int ST_IDX_LSB = 5;
  localparam int ST_LVL_LSB = 8;
  localparam int ST_MIN_W = 10;

  // Permission-check error codes
  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_PROT = 2'd2;
  localparam logic [1:0] ERR_PRIV = 2'd3;

  typedef struct packed {
    logic recordFault;
    logic clearStatus;
    logic useWalkType;
  } ctlStrobe_t;

  // Rights granted by an access field, as {R,W,X}
  function automatic logic [2:0] grantRwx(input logic [2:0] acc, input logic sup);
    logic [2:0] g;
    case (acc)
      3'd0: g = 3'b100;
      3'd1: g = 3'b110;
      3'd2: g = 3'b101;
      3'd3: g = 3'b111;
      3'd4: g = 3'b001;
      3'd5: g = sup ? 3'b110 : 3'b100;
      3'd6: g = sup ? 3'b101 : 3'b000;
      default: g = sup ? 3'b111 : 3'b000;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pgchk_datapath.sv
module pgchk_datapath
  import pgchk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ENTRY_W = 32,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqFetch,
  input  logic                reqUser,
  input  logic [ENTRY_W-1:0]  leafEntry,
  input  logic [2:0]          walkFaultType,
  input  logic [1:0]          walkLevel,
  input  ctlStrobe_t          strobe,
  output logic [1:0]          errCode,
  output logic [2:0]          entryMask,
  output logic                entryModified,
  output logic [STATUS_W-1:0] statusQ,
  output logic [ADDR_W-1:0]   addrQ
);

  localparam int LVL_W = 2;
  localparam int IDX_W = 3;

  logic [IDX_W-1:0]    accIdx;
  logic [2:0]          accField;
  logic                isSup;
  logic [2:0]          grant;
  logic [2:0]          need;
  logic [2:0]          faultType;
  logic [STATUS_W-1:0] faultWord;
  logic [STATUS_W-1:0] statusD;
  logic                unusedEntryBits;

  assign isSup = ~reqUser;
  assign accIdx = {reqWrite, reqFetch, isSup};
  assign accField = leafEntry[ENT_ACC_LSB +: 3];
  assign entryModified = leafEntry[ENT_MOD_BIT];
  assign unusedEntryBits = ^leafEntry;

  assign grant = grantRwx(accField, isSup);
  assign need = {~reqWrite & ~reqFetch, reqWrite, reqFetch};

  always_comb begin
    if (!isSup && accField[2:1] == 2'b11) errCode = ERR_PRIV;
    else if ((need & ~grant) != 3'b000)   errCode = ERR_PROT;
    else                                  errCode = ERR_NONE;
  end

  assign entryMask = {grant[2], grant[1] & entryModified, grant[0]};

  assign faultType = strobe.useWalkType ? walkFaultType : {1'b0, errCode};

  always_comb begin
    faultWord = '0;
    faultWord[ST_LVL_LSB +: LVL_W] = walkLevel;
    faultWord[ST_IDX_LSB +: IDX_W] = accIdx;
    faultWord[ST_TYPE_LSB +: 3] = faultType;
    faultWord[ST_VAL_BIT] = 1'b1;
    if (statusQ != '0 && !strobe.clearStatus) faultWord[ST_OVF_BIT] = 1'b1;
  end

  always_comb begin
    statusD = statusQ;
    if (strobe.recordFault)      statusD = faultWord;
    else if (strobe.clearStatus) statusD = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      addrQ <= '0;
    end else begin
      statusQ <= statusD;
      if (strobe.recordFault) addrQ <= reqAddr;
    end
  end

  // R5: a recorded fault always leaves the valid bit set
  p_valid_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recordFault |=> statusQ[ST_VAL_BIT]);

  // R7: the faulting address is captured
  p_addr_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recordFault |=> addrQ == $past(reqAddr));

  // R6: an unread earlier fault raises overflow
  p_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.recordFault && statusQ != '0 && !strobe.clearStatus) |=> statusQ[ST_OVF_BIT]);

  // R9: a read with no new fault empties the status word
  p_read_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearStatus && !strobe.recordFault) |=> statusQ == '0);

  // R11: quiet cycles leave both registers untouched
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearStatus && !strobe.recordFault) |=> ($stable(statusQ) && $stable(addrQ)));

endmodule

// File: rtl/pgchk_control.sv
module pgchk_control
  import pgchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqFetch,
  input  logic       reqUser,
  input  logic [2:0] walkFaultType,
  input  logic       noFault,
  input  logic       trapsEnabled,
  input  logic       statusRead,
  input  logic [1:0] errCode,
  input  logic [2:0] entryMask,
  input  logic       entryModified,
  output ctlStrobe_t strobe,
  output logic       permitted,
  output logic [2:0] rwxOut,
  output logic       trapInstr,
  output logic       trapData
);

  logic walkFault;
  logic permErr;
  logic fault;
  logic fullGrant;
  logic trapReq;

  assign walkFault = walkFaultType != 3'd0;
  assign permErr = (errCode != ERR_NONE) && !(noFault && reqUser);
  assign fault = reqValid && (walkFault || permErr);
  assign fullGrant = fault && (noFault || !trapsEnabled);
  assign trapReq = fault && !fullGrant;

  assign permitted = reqValid && !trapReq;
  assign trapInstr = trapReq && reqFetch;
  assign trapData = trapReq && !reqFetch;

  always_comb begin
    if (!reqValid || trapReq) rwxOut = 3'b000;
    else if (fullGrant)       rwxOut = 3'b111;
    else                      rwxOut = entryMask;
  end

  always_comb begin
    strobe.recordFault = fault;
    strobe.clearStatus = statusRead;
    strobe.useWalkType = walkFault;
  end

  // R8: a trap only when trapping is allowed
  p_trap_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (trapInstr || trapData) |-> (trapsEnabled && !noFault && reqValid));

  // R8: never both trap kinds at once
  p_one_trap_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trapInstr, trapData}));

  // R3: write right on an entry grant needs the modified bit
  p_write_needs_mod_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rwxOut[1] && !fullGrant) |-> entryModified);

  // R11: nothing is decided without a request
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!permitted && rwxOut == 3'b000 && !strobe.recordFault));

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
  import pgchk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ENTRY_W = 32,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWrite,
  input  logic                reqFetch,
  input  logic                reqUser,
  input  logic [ENTRY_W-1:0]  leafEntry,
  input  logic [2:0]          walkFaultType,
  input  logic [1:0]          walkLevel,
  input  logic                noFault,
  input  logic                trapsEnabled,
  input  logic                statusRead,
  output logic                permitted,
  output logic                permR,
  output logic                permW,
  output logic                permX,
  output logic                trapInstr,
  output logic                trapData,
  output logic [STATUS_W-1:0] faultStatus,
  output logic [ADDR_W-1:0]   faultAddr
);

  ctlStrobe_t strobe;
  logic [1:0] errCode;
  logic [2:0] entryMask;
  logic       entryModified;
  logic [2:0] rwxOut;

  pgchk_datapath #(
    .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .STATUS_W(STATUS_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqFetch(reqFetch), .reqUser(reqUser), .leafEntry(leafEntry),
    .walkFaultType(walkFaultType), .walkLevel(walkLevel), .strobe(strobe),
    .errCode(errCode), .entryMask(entryMask), .entryModified(entryModified),
    .statusQ(faultStatus), .addrQ(faultAddr)
  );

  pgchk_control i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFetch(reqFetch),
    .reqUser(reqUser), .walkFaultType(walkFaultType), .noFault(noFault),
    .trapsEnabled(trapsEnabled), .statusRead(statusRead), .errCode(errCode),
    .entryMask(entryMask), .entryModified(entryModified), .strobe(strobe),
    .permitted(permitted), .rwxOut(rwxOut), .trapInstr(trapInstr),
    .trapData(trapData)
  );

  assign {permR, permW, permX} = rwxOut;

  initial begin
    if (STATUS_W < ST_MIN_W) $error("STATUS_W too small for the status layout");
  end

endmodule

// File: tb/test_pgchk_top.sv
module test_pgchk_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqFetch = 1'b0;
  logic        reqUser = 1'b0;
  logic [31:0] leafEntry = '0;
  logic [2:0]  walkFaultType = '0;
  logic [1:0]  walkLevel = '0;
  logic        noFault = 1'b0;
  logic        trapsEnabled = 1'b1;
  logic        statusRead = 1'b0;
  logic        permitted, permR, permW, permX, trapInstr, trapData;
  logic [31:0] faultStatus, faultAddr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgchk_top i_pgchk_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqFetch(reqFetch), .reqUser(reqUser),
    .leafEntry(leafEntry), .walkFaultType(walkFaultType), .walkLevel(walkLevel),
    .noFault(noFault), .trapsEnabled(trapsEnabled), .statusRead(statusRead),
    .permitted(permitted), .permR(permR), .permW(permW), .permX(permX),
    .trapInstr(trapInstr), .trapData(trapData), .faultStatus(faultStatus),
    .faultAddr(faultAddr)
  );

  // {req[4], user, write, fetch, acc[3], mod, nf, te, permit, rwx[3], trapI, trapD}
  localparam logic [18:0] VECS [NVEC] = '{
    {4'd1, 1'b0, 1'b0, 1'b0, 3'd6, 1'b1, 1'b0, 1'b1, 1'b1, 3'b101, 1'b0, 1'b0},
    {4'd1, 1'b1, 1'b0, 1'b0, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1},
    {4'd2, 1'b1, 1'b0, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 3'b100, 1'b0, 1'b0},
    {4'd2, 1'b0, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 3'b110, 1'b0, 1'b0},
    {4'd1, 1'b1, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1},
    {4'd2, 1'b1, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0, 1'b0},
    {4'd1, 1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1},
    {4'd8, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0},
    {4'd2, 1'b0, 1'b1, 1'b1, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 3'b111, 1'b0, 1'b0},
    {4'd8, 1'b0, 1'b1, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0},
    {4'd3, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 3'b101, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 3'b100, 1'b0, 1'b0},
    {4'd4, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0},
    {4'd4, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 3'b101, 1'b0, 1'b0},
    {4'd8, 1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 3'b111, 1'b0, 1'b0},
    {4'd8, 1'b1, 1'b0, 1'b0, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 3'b111, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Build an entry: access field at [4:2], modified bit at [6]
  function automatic logic [31:0] mkEntry(input logic [2:0] acc, input logic md);
    return 32'hABCD_0000 | (32'(acc) << 2) | (32'(md) << 6);
  endfunction

  task automatic drive(input logic v, input logic u, input logic w, input logic f,
                       input logic [2:0] acc, input logic md, input logic nf,
                       input logic te, input logic [2:0] wft, input logic [1:0] lvl,
                       input logic [31:0] addr, input logic rd);
    reqValid = v; reqUser = u; reqWrite = w; reqFetch = f;
    leafEntry = mkEntry(acc, md); noFault = nf; trapsEnabled = te;
    walkFaultType = wft; walkLevel = lvl; reqAddr = addr; statusRead = rd;
  endtask

  function automatic logic [31:0] decisions();
    return {26'd0, permitted, permR, permW, permX, trapInstr, trapData};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 status after reset", faultStatus, 32'h0);
    check("R11 address after reset", faultAddr, 32'h0);
    check("R11 idle decisions", decisions(), 32'h0);

    // Table of decisions (R1 R2 R3 R4 R8)
    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] v;
      v = VECS[i];
      @(negedge clk);
      drive(1'b1, v[14], v[13], v[12], v[11:9], v[8], v[7], v[6], 3'd0, 2'd0,
            32'h1000 + 32'(i), 1'b1);
      #1;
      check($sformatf("R%0d vector %0d", v[18:15], i), decisions(),
            {26'd0, v[5], v[4:2], v[1], v[0]});
    end

    // Clear the status word, quiet
    @(negedge clk);
    drive(1'b0, 0, 0, 0, 3'd0, 1, 0, 1, 3'd0, 2'd0, 32'h0, 1'b1);
    @(negedge clk);
    statusRead = 1'b0;
    check("R9 cleared before sequence", faultStatus, 32'h0);

    // R5 R7: first fault, user read of field 6 at level 3
    drive(1'b1, 1, 0, 0, 3'd6, 1, 0, 1, 3'd0, 2'd3, 32'hCAFE_0123, 1'b0);
    @(negedge clk);
    check("R5 first fault word", faultStatus, 32'h30E);
    check("R7 first fault address", faultAddr, 32'hCAFE_0123);

    // R6: second fault while unread, supervisor write of field 4 at level 2
    drive(1'b1, 0, 1, 0, 3'd4, 1, 0, 1, 3'd0, 2'd2, 32'h0BAD_F00D, 1'b0);
    @(negedge clk);
    check("R6 overflow word", faultStatus, 32'h2AB);
    check("R7 second fault address", faultAddr, 32'h0BAD_F00D);

    // R9: read shows the value, then clears
    drive(1'b0, 0, 0, 0, 3'd0, 1, 0, 1, 3'd0, 2'd0, 32'h0, 1'b1);
    #1;
    check("R9 value visible during read", faultStatus, 32'h2AB);
    @(negedge clk);
    check("R9 cleared after read", faultStatus, 32'h0);
    check("R9 address kept after read", faultAddr, 32'h0BAD_F00D);

    // R10: walker fault, user fetch, no-fault mode: not suppressed, full grant
    drive(1'b1, 1, 0, 1, 3'd3, 1, 1, 1, 3'd1, 2'd1, 32'h7777_0000, 1'b0);
    #1;
    check("R10 walker fault full grant", decisions(), 32'b111100);
    @(negedge clk);
    check("R10 walker fault word", faultStatus, 32'h146);
    check("R10 walker fault address", faultAddr, 32'h7777_0000);

    // R9: fault and read in the same cycle, supervisor read of field 4
    drive(1'b1, 0, 0, 0, 3'd4, 1, 0, 1, 3'd0, 2'd0, 32'h5555_AAAA, 1'b1);
    #1;
    check("R8 data trap", decisions(), 32'b000001);
    @(negedge clk);
    check("R9 read with fault, no overflow", faultStatus, 32'h02A);

    // R11: idle with fault-inducing fields changes nothing
    drive(1'b0, 1, 0, 0, 3'd6, 1, 0, 1, 3'd2, 2'd3, 32'h1234_5678, 1'b0);
    #1;
    check("R11 idle decisions", decisions(), 32'h0);
    @(negedge clk);
    check("R11 status held when idle", faultStatus, 32'h02A);
    check("R11 address held when idle", faultAddr, 32'h5555_AAAA);

    // R4: suppressed user error records nothing
    drive(1'b1, 1, 0, 0, 3'd6, 1, 1, 1, 3'd0, 2'd3, 32'h9999_0000, 1'b0);
    @(negedge clk);
    check("R4 no status change", faultStatus, 32'h02A);
    check("R4 no address change", faultAddr, 32'h5555_AAAA);

    // R8: fetch fault with traps disabled: no trap, full grant, recorded with overflow
    drive(1'b1, 1, 0, 1, 3'd0, 1, 0, 0, 3'd0, 2'd0, 32'h4444_0000, 1'b0);
    #1;
    check("R8 traps off full grant", decisions(), 32'b111100);
    @(negedge clk);
    check("R6 overflow on traps-off fault", faultStatus, 32'h04B);

    drive(1'b0, 0, 0, 0, 3'd0, 1, 0, 1, 3'd0, 2'd0, 32'h0, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule